// File: doc/BRIEF.md
# Two-Entry Byte Buffers with Service Interrupts

This block sits between a 16-bit register port and a serial bus engine. It holds one small byte buffer for each direction. Software fills the transmit buffer and the engine drains it. The engine fills the receive buffer and software drains it. Either side can move one byte per access through an 8-bit port, or two bytes at once through a 16-bit port.

Each buffer reports how full it is as a 2-bit code. Each buffer can be held empty by a flush control. Each buffer raises a service request when software should act, and the service threshold can be set to one byte or to two bytes.

An interrupt status register collects six completion and error events from the engine side and the two service requests. Each status bit is cleared by writing a 1 to it. A mask selects which status bits drive the single interrupt line.

Registers are 16 bits wide on a 32-bit aligned grid. The port carries the word index, so the byte offset is four times the index. A read returns its data in the cycle after the read strobe.

Top module: `bytebuf_irq`

## Requirements
- R1: The transmit buffer holds up to two bytes and releases them in arrival order. `eng_tx_valid` is high while it holds any byte, `eng_tx_data` shows the oldest byte, and `eng_tx_take` removes that byte. Its fill code is read at bits [1:0] of the buffer status register (word 3): 00 means empty, 01 means one byte, 11 means two bytes, and 10 never appears.
- R2: The receive buffer holds up to two bytes. `eng_rx_ready` is high while it has a free entry. `eng_rx_push` stores `eng_rx_data` only when that is so; otherwise the byte is dropped. Its fill code, with the same encoding as R1, is read at bits [3:2] of word 3.
- R3: Writing word 4 stores wdata[7:0] as one byte. Writing word 5 stores two bytes, wdata[7:0] first, and only when the transmit buffer is empty. Reading word 6 removes one byte and returns it in bits [7:0]. Reading word 7 removes two bytes, oldest in bits [7:0], and only when the receive buffer is full.
- R4: Buffer control (word 2) bit 0 flushes the transmit buffer and bit 1 flushes the receive buffer. From the cycle after the bit is written as 1, and for as long as it stays 1, that buffer is empty and any byte offered to it is dropped.
- R5: Transmit service is requested when the transmit buffer has at least one free entry, or, with control bit 2 set, only when it is empty. Receive service is requested when the receive buffer holds at least one byte, or, with control bit 3 set, only when it holds two.
- R6: A write to word 4 while the transmit buffer is full, or to word 5 while it is not empty, stores nothing and pulses `buf_wr_err` for one cycle, in the cycle after the write.
- R7: A read of word 6 while the receive buffer is empty, or of word 7 while it is not full, removes nothing, returns zero, and pulses `buf_rd_err` for one cycle.
- R8: Interrupt status (word 0) has these bits. Bits 0 to 5 follow `evt_set[5:0]`: slave start, slave done, slave error, slave overflow, master done and master error. Bit 6 is transmit service and bit 7 is receive service. A status bit is set in the cycle after its event or request. Writing a 1 to a bit clears it. When a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit and its matching bit of the mask register (word 1) are both 1.
- R10: After reset both buffers are empty, and status, mask, control, read data and both error pulses are zero.
- R11: Reading word 1 or word 2 returns the mask or the control value. Reading word 4 returns the oldest transmit byte without removing it. Reading word 5 returns both held transmit bytes, oldest in bits [7:0], with zero in any empty entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_word | input | 3 | Register word index (byte offset divided by four) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the cycle after `reg_rd` |
| evt_set | input | 6 | One-cycle event pulses that set status bits 0 to 5 |
| eng_tx_valid | output | 1 | Transmit buffer holds at least one byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine removes the oldest transmit byte |
| eng_rx_ready | output | 1 | Receive buffer has a free entry |
| eng_rx_push | input | 1 | Engine offers a received byte |
| eng_rx_data | input | 8 | Received byte |
| buf_wr_err | output | 1 | Pulse after a transmit write that did not fit |
| buf_rd_err | output | 1 | Pulse after a receive read that found too few bytes |
| irq | output | 1 | Masked interrupt request |

## Verification
The hard case is a status bit being set and cleared in the same cycle. This happens when software writes a 1 to clear a bit while an event pulse, or a service request that is still active, sets that same bit. The bench provokes this directly by driving a write to word 0 together with a matching `evt_set` pulse. The random phase also produces it many times, because the service bits are set again on every cycle their condition holds. The bench judges the result by reading word 0 back and by watching `irq` against a model in which the set always wins over the clear.

// File: rtl/bytebuf_pkg.sv
// Shared widths, register selectors and the fill-code mapping for the
// byte buffer block. Assumes a two-entry buffer in each direction.
package bytebuf_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int EVT_N  = 6;
    localparam int STAT_N = EVT_N + 2;
    localparam int WA_W   = 3;

    typedef enum logic [WA_W-1:0] {
        RG_ISTAT = 3'd0,
        RG_IMASK = 3'd1,
        RG_FCTRL = 3'd2,
        RG_FSTAT = 3'd3,
        RG_TX8   = 3'd4,
        RG_TX16  = 3'd5,
        RG_RX8   = 3'd6,
        RG_RX16  = 3'd7
    } reg_sel_t;

    // Map an entry count (0..2) onto the 2-bit fill code; 10 is never produced.
    function automatic logic [1:0] fill_code(input logic [1:0] cnt);
        case (cnt)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction
endpackage

// File: rtl/byte_fifo2.sv
// Two-entry byte buffer. Per cycle it accepts up to two bytes (low byte
// first) and releases up to two. A held flush empties it and drops
// pushes. Assumes the caller never pops more than it holds and never
// pushes more than the free space counted before any pop.
module byte_fifo2 #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [1:0]          push_n,
    input  logic [2*DATA_W-1:0] push_data,
    input  logic [1:0]          pop_n,
    output logic [1:0]          count,
    output logic [DATA_W-1:0]   head,
    output logic [DATA_W-1:0]   next_entry
);
    logic [DATA_W-1:0] e0_q, e1_q, e0_d, e1_d;
    logic [1:0]        cnt_q, cnt_d, base;

    // Shift out popped entries, then place pushed bytes behind the survivors.
    always_comb begin
        e0_d  = (pop_n == 2'd0) ? e0_q : (pop_n == 2'd1) ? e1_q : '0;
        e1_d  = (pop_n == 2'd0) ? e1_q : '0;
        base  = cnt_q - pop_n;
        if (push_n != 2'd0) begin
            if (base[0]) e1_d = push_data[DATA_W-1:0];
            else         e0_d = push_data[DATA_W-1:0];
        end
        if (push_n == 2'd2) e1_d = push_data[2*DATA_W-1:DATA_W];
        cnt_d = cnt_q - pop_n + push_n;
        if (flush) begin
            e0_d  = '0;
            e1_d  = '0;
            cnt_d = 2'd0;
        end
    end

    // Storage and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e0_q  <= '0;
            e1_q  <= '0;
            cnt_q <= 2'd0;
        end else begin
            e0_q  <= e0_d;
            e1_q  <= e1_d;
            cnt_q <= cnt_d;
        end
    end

    assign count      = cnt_q;
    assign head       = e0_q;
    assign next_entry = e1_q;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != 2'd3);

    // R4
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == 2'd0));

    // R1
    fifo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n == 2'd1 && cnt_q == 2'd2 && !flush) |=> (e0_q == $past(e1_q)));
endmodule

// File: rtl/irq_status.sv
// Interrupt status with write-1-to-clear bits, a mask register and one
// masked request line. A set in the same cycle as a clear wins.
module irq_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] stat,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] mask_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        // One sticky status bit: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (set[g]) bit_q <= 1'b1;
            else if (clr[g]) bit_q <= 1'b0;
        end
        assign stat[g] = bit_q;
    end

    // Mask register written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end

    assign mask = mask_q;
    assign irq  = |(stat & mask_q);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & $past(set)) == $past(set)));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat & $past(clr) & ~$past(set)) == '0));
endmodule

// File: rtl/bytebuf_irq.sv
// Top of the byte buffer block. Decodes the 16-bit register port,
// admits or rejects buffer accesses against the occupancy seen at the
// start of the cycle, and feeds the service requests and engine events
// into the interrupt status. Assumes reg_wr and reg_rd are not both high.
module bytebuf_irq
    import bytebuf_pkg::*;
#(
    parameter int AW = WA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_word,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [EVT_N-1:0]  evt_set,
    output logic              eng_tx_valid,
    output logic [BYTE_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    output logic              eng_rx_ready,
    input  logic              eng_rx_push,
    input  logic [BYTE_W-1:0] eng_rx_data,
    output logic              buf_wr_err,
    output logic              buf_rd_err,
    output logic              irq
);
    reg_sel_t          sel;
    logic              wr_tx8, wr_tx16, rd_rx8, rd_rx16;
    logic [3:0]        ctrl_q;
    logic [1:0]        tx_cnt, rx_cnt, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [BYTE_W-1:0] tx_head, tx_next, rx_head, rx_next;
    logic              tx_serv, rx_serv, wr_err_d, rd_err_d;
    logic [STAT_N-1:0] st_set, st_clr, stat, mask;
    logic [REG_W-1:0]  rdata_q;
    logic              wr_err_q, rd_err_q;

    // Register decode.
    always_comb begin
        sel     = reg_sel_t'(reg_word[WA_W-1:0]);
        wr_tx8  = reg_wr && (sel == RG_TX8);
        wr_tx16 = reg_wr && (sel == RG_TX16);
        rd_rx8  = reg_rd && (sel == RG_RX8);
        rd_rx16 = reg_rd && (sel == RG_RX16);
    end

    // Admission against the occupancy at the start of the cycle.
    always_comb begin
        tx_push_n = (wr_tx8 && tx_cnt != 2'd2) ? 2'd1 :
                    (wr_tx16 && tx_cnt == 2'd0) ? 2'd2 : 2'd0;
        wr_err_d  = (wr_tx8 && tx_cnt == 2'd2) || (wr_tx16 && tx_cnt != 2'd0);
        tx_pop_n  = (eng_tx_take && tx_cnt != 2'd0) ? 2'd1 : 2'd0;
        rx_pop_n  = (rd_rx8 && rx_cnt != 2'd0) ? 2'd1 :
                    (rd_rx16 && rx_cnt == 2'd2) ? 2'd2 : 2'd0;
        rd_err_d  = (rd_rx8 && rx_cnt == 2'd0) || (rd_rx16 && rx_cnt != 2'd2);
        rx_push_n = (eng_rx_push && rx_cnt != 2'd2) ? 2'd1 : 2'd0;
    end

    byte_fifo2 #(.DATA_W(BYTE_W)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_q[0]),
        .push_n(tx_push_n), .push_data(reg_wdata), .pop_n(tx_pop_n),
        .count(tx_cnt), .head(tx_head), .next_entry(tx_next)
    );

    byte_fifo2 #(.DATA_W(BYTE_W)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_q[1]),
        .push_n(rx_push_n), .push_data({{BYTE_W{1'b0}}, eng_rx_data}), .pop_n(rx_pop_n),
        .count(rx_cnt), .head(rx_head), .next_entry(rx_next)
    );

    // Service requests from occupancy and the threshold bits.
    always_comb begin
        tx_serv = ctrl_q[2] ? (tx_cnt == 2'd0) : (tx_cnt != 2'd2);
        rx_serv = ctrl_q[3] ? (rx_cnt == 2'd2) : (rx_cnt != 2'd0);
        st_set  = {rx_serv, tx_serv, evt_set};
        st_clr  = (reg_wr && sel == RG_ISTAT) ? reg_wdata[STAT_N-1:0] : '0;
    end

    irq_status #(.N(STAT_N)) i_irq_status (
        .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr),
        .mask_we(reg_wr && sel == RG_IMASK), .mask_wd(reg_wdata[STAT_N-1:0]),
        .stat(stat), .mask(mask), .irq(irq)
    );

    // Buffer control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ctrl_q <= 4'd0;
        else if (reg_wr && sel == RG_FCTRL) ctrl_q <= reg_wdata[3:0];
    end

    // Registered read data and one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            wr_err_q <= 1'b0;
            rd_err_q <= 1'b0;
        end else begin
            wr_err_q <= wr_err_d;
            rd_err_q <= rd_err_d;
            if (reg_rd) begin
                case (sel)
                    RG_ISTAT: rdata_q <= {{(REG_W-STAT_N){1'b0}}, stat};
                    RG_IMASK: rdata_q <= {{(REG_W-STAT_N){1'b0}}, mask};
                    RG_FCTRL: rdata_q <= {12'd0, ctrl_q};
                    RG_FSTAT: rdata_q <= {12'd0, fill_code(rx_cnt), fill_code(tx_cnt)};
                    RG_TX8:   rdata_q <= {{BYTE_W{1'b0}}, tx_head};
                    RG_TX16:  rdata_q <= {tx_next, tx_head};
                    RG_RX8:   rdata_q <= (rx_cnt != 2'd0) ? {{BYTE_W{1'b0}}, rx_head} : '0;
                    default:  rdata_q <= (rx_cnt == 2'd2) ? {rx_next, rx_head} : '0;
                endcase
            end
        end
    end

    assign reg_rdata    = rdata_q;
    assign buf_wr_err   = wr_err_q;
    assign buf_rd_err   = rd_err_q;
    assign eng_tx_valid = (tx_cnt != 2'd0);
    assign eng_tx_data  = tx_head;
    assign eng_rx_ready = (rx_cnt != 2'd2);

    // R7
    rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx8 && rx_cnt == 2'd0) |=> (reg_rdata == '0 && buf_rd_err));

    // R6
    wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx8 && tx_cnt == 2'd2 && !eng_tx_take && !ctrl_q[0]) |=> (tx_cnt == 2'd2 && buf_wr_err));

    // R2
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_cnt == 2'd2 && rx_pop_n == 2'd0 && !ctrl_q[1]) |=> (rx_cnt == 2'd2));
endmodule

// File: tb/test_bytebuf_irq.sv
module test_bytebuf_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_word = 3'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [5:0]  evt_set = 6'd0;
    logic        eng_tx_valid, eng_rx_ready, buf_wr_err, buf_rd_err, irq;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_take = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = 8'd0;

    int checks = 0;
    int errors = 0;

    // model state
    logic [1:0]  m_tc = 0, m_rc = 0;
    logic [7:0]  m_tq [2] = '{8'd0, 8'd0};
    logic [7:0]  m_rq [2] = '{8'd0, 8'd0};
    logic [7:0]  m_st = 0, m_mk = 0;
    logic [3:0]  m_ct = 0;

    always #4 clk = ~clk;

    bytebuf_irq i_bytebuf_irq (
        .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
        .eng_rx_ready(eng_rx_ready), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .buf_wr_err(buf_wr_err), .buf_rd_err(buf_rd_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code(input logic [1:0] c);
        return (c == 2'd0) ? 2'b00 : (c == 2'd1) ? 2'b01 : 2'b11;
    endfunction

    // One clock: drive, let the edge pass, update the model, compare at negedge.
    task automatic cyc(input bit w, input bit r, input logic [2:0] sel, input logic [15:0] d,
                       input bit take, input bit push, input logic [7:0] pb, input logic [5:0] ev);
        logic [7:0]  set, clr;
        logic [15:0] e_rd;
        bit          e_we, e_re;
        logic [1:0]  tpush, tc0, rc0;
        bit          tpop;
        logic [1:0]  rpop;
        bit          rpush;
        reg_wr = w; reg_rd = r; reg_word = sel; reg_wdata = d;
        eng_tx_take = take; eng_rx_push = push; eng_rx_data = pb; evt_set = ev;
        @(posedge clk);
        tc0 = m_tc; rc0 = m_rc;
        set = {(m_ct[3] ? (rc0 == 2) : (rc0 != 0)), (m_ct[2] ? (tc0 == 0) : (tc0 != 2)), ev};
        clr = (w && sel == 3'd0) ? d[7:0] : 8'd0;
        e_we = 0; e_re = 0; tpush = 0; rpop = 0; e_rd = 16'd0;
        tpop  = take && tc0 != 0;
        rpush = push && rc0 != 2;
        if (w && sel == 3'd4) begin if (tc0 != 2) tpush = 1; else e_we = 1; end
        if (w && sel == 3'd5) begin if (tc0 == 0) tpush = 2; else e_we = 1; end
        if (r) case (sel)
            3'd0: e_rd = {8'd0, m_st};
            3'd1: e_rd = {8'd0, m_mk};
            3'd2: e_rd = {12'd0, m_ct};
            3'd3: e_rd = {12'd0, code(rc0), code(tc0)};
            3'd4: e_rd = {8'd0, m_tq[0]};
            3'd5: e_rd = {m_tq[1], m_tq[0]};
            3'd6: if (rc0 != 0) begin e_rd = {8'd0, m_rq[0]}; rpop = 1; end else e_re = 1;
            default: if (rc0 == 2) begin e_rd = {m_rq[1], m_rq[0]}; rpop = 2; end else e_re = 1;
        endcase
        // transmit buffer update
        if (tpop) begin m_tq[0] = m_tq[1]; m_tq[1] = 0; m_tc = m_tc - 1; end
        if (tpush != 0) begin m_tq[m_tc[0]] = d[7:0]; m_tc = m_tc + 1; end
        if (tpush == 2) begin m_tq[1] = d[15:8]; m_tc = m_tc + 1; end
        if (m_ct[0]) begin m_tc = 0; m_tq[0] = 0; m_tq[1] = 0; end
        // receive buffer update
        if (rpop == 1) begin m_rq[0] = m_rq[1]; m_rq[1] = 0; m_rc = m_rc - 1; end
        if (rpop == 2) begin m_rq[0] = 0; m_rq[1] = 0; m_rc = 0; end
        if (rpush) begin m_rq[m_rc[0]] = pb; m_rc = m_rc + 1; end
        if (m_ct[1]) begin m_rc = 0; m_rq[0] = 0; m_rq[1] = 0; end
        m_st = (m_st & ~clr) | set;
        if (w && sel == 3'd1) m_mk = d[7:0];
        if (w && sel == 3'd2) m_ct = d[3:0];
        @(negedge clk);
        chk("R1 tx valid", {15'd0, eng_tx_valid}, {15'd0, m_tc != 0});
        if (m_tc != 0) chk("R1 tx head", {8'd0, eng_tx_data}, {8'd0, m_tq[0]});
        chk("R2 rx ready", {15'd0, eng_rx_ready}, {15'd0, m_rc != 2});
        chk("R6 wr err", {15'd0, buf_wr_err}, {15'd0, e_we});
        chk("R7 rd err", {15'd0, buf_rd_err}, {15'd0, e_re});
        chk("R9 irq", {15'd0, irq}, {15'd0, |(m_st & m_mk)});
        if (r) case (sel)
            3'd0:       chk("R5/R8 status read", reg_rdata, e_rd);
            3'd3:       chk("R1/R2/R4 fill read", reg_rdata, e_rd);
            3'd6, 3'd7: chk("R3 rx read", reg_rdata, e_rd);
            default:    chk("R11 reg read", reg_rdata, e_rd);
        endcase
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        cyc(1, 0, s, d, 0, 0, 8'd0, 6'd0);
    endtask
    task automatic rd(input logic [2:0] s);
        cyc(0, 1, s, 16'd0, 0, 0, 8'd0, 6'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act 0 exp 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_b0f1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 tx empty", {15'd0, eng_tx_valid}, 16'd0);
        chk("R10 rx ready", {15'd0, eng_rx_ready}, 16'd1);
        chk("R10 irq", {15'd0, irq}, 16'd0);
        chk("R10 errs", {14'd0, buf_wr_err, buf_rd_err}, 16'd0);
        chk("R10 rdata", reg_rdata, 16'd0);
        rst_n = 1'b1;
        rd(3'd0);
        rd(3'd6);                       // R7 empty read
        rd(3'd7);
        wr(3'd4, 16'h0011); wr(3'd4, 16'h0022);
        wr(3'd4, 16'h0033);             // R6 full write
        rd(3'd3); rd(3'd5); rd(3'd4);   // R11 peek
        cyc(0, 0, 3'd0, 16'd0, 1, 0, 8'd0, 6'd0);
        wr(3'd5, 16'h4455);             // R6 not empty
        cyc(0, 0, 3'd0, 16'd0, 1, 0, 8'd0, 6'd0);
        wr(3'd5, 16'h6677);             // R3 two-byte write
        rd(3'd3);
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'hA1, 6'd0);
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'hB2, 6'd0);
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'hC3, 6'd0);  // R2 dropped
        rd(3'd3); rd(3'd7);                         // R3 order
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'hD4, 6'd0);
        rd(3'd7);                                   // R7 not full
        rd(3'd6);
        cyc(1, 0, 3'd0, 16'h0010, 0, 0, 8'd0, 6'h10); // R8 set beats clear
        rd(3'd0);
        wr(3'd0, 16'hFFFF); rd(3'd0);
        wr(3'd1, 16'h0010); rd(3'd1);               // R9 mask
        cyc(0, 0, 3'd0, 16'd0, 0, 0, 8'd0, 6'h10);
        wr(3'd1, 16'h00FF);
        wr(3'd2, 16'h000C); rd(3'd2);               // R5 thresholds
        wr(3'd0, 16'h00FF); rd(3'd0);
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'h5A, 6'd0);
        wr(3'd0, 16'h00FF); rd(3'd0);
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'h5B, 6'd0);
        wr(3'd0, 16'h00FF); rd(3'd0);
        wr(3'd2, 16'h0003); wr(3'd4, 16'h0099);     // R4 flush held
        cyc(0, 0, 3'd0, 16'd0, 0, 1, 8'h77, 6'd0);
        rd(3'd3);
        wr(3'd2, 16'h0000); wr(3'd4, 16'h0088); rd(3'd3);
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [15:0] d;
            bit take, push;
            logic [5:0] ev;
            op   = $urandom_range(0, 15);
            d    = 16'($urandom);
            take = ($urandom_range(0, 2) == 0);
            push = ($urandom_range(0, 2) == 0);
            ev   = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd0;
            case (op)
                0, 1:   cyc(1, 0, 3'd4, d, take, push, d[15:8], ev);
                2:      cyc(1, 0, 3'd5, d, take, push, d[15:8], ev);
                3, 4:   cyc(0, 1, 3'd6, d, take, push, d[7:0], ev);
                5:      cyc(0, 1, 3'd7, d, take, push, d[7:0], ev);
                6:      cyc(0, 1, 3'd3, d, take, push, d[7:0], ev);
                7:      cyc(0, 1, 3'd0, d, take, push, d[7:0], ev);
                8:      cyc(1, 0, 3'd0, d, take, push, d[7:0], ev);
                9:      cyc(1, 0, 3'd1, d, take, push, d[7:0], ev);
                10:     cyc(1, 0, 3'd2, {d[15:2], (d[5:3] == 3'd0) ? d[1:0] : 2'b00},
                            take, push, d[7:0], ev);
                11:     cyc(0, 1, 3'($urandom_range(1, 5)), d, take, push, d[7:0], ev);
                default: cyc(0, 0, 3'd0, d, take, push, d[7:0], ev);
            endcase
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule